// File: doc/BRIEF.md
# Programmable-Frame Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. The character shape comes from a six-bit line-control word: five to eight data bits, optional parity (odd, even or a fixed value) and one or two stop bits. The bit rate comes from an integer divisor and a three-bit fraction that together set the length of a 16x oversampling tick. Both are supplied by a register block outside this one and are sampled when each frame starts.

A byte is offered with a one-cycle write strobe. It waits in a one-deep holding register until the shifter is free, and is then moved into the shifter. Two flags report whether the holding register is free and whether the whole transmitter is idle. A one-cycle done pulse, meant for interrupt logic, marks the end of every frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, txLine is 1, bufEmpty is 1, txEmpty is 1 and txDone is 0.
- R2: A frame starts with one low start bit and then sends lineCtrl[1:0]+5 data bits, least significant first. Data bits above that count are not sent.
- R3: lineCtrl[2]=1 ends the frame with two high stop bits. lineCtrl[2]=0 ends it with one.
- R4: lineCtrl[5]=1 inserts a parity bit after the data bits. With lineCtrl[4]=0, that bit gives even parity over the sent data bits when lineCtrl[3]=1 and odd parity when lineCtrl[3]=0.
- R5: With lineCtrl[5]=1 and lineCtrl[4]=1, the parity bit is fixed at the inverse of lineCtrl[3].
- R6: Every bit lasts exactly 16*divInt + divFrac + 16 clock cycles.
- R7: While divInt is 0, no frame starts and txLine stays high. A byte written in this state waits in the holding register (bufEmpty=0). It is sent once divInt becomes nonzero.
- R8: Writing a byte while bufEmpty=1 makes bufEmpty and txEmpty 0 on the next cycle. bufEmpty returns to 1 on the cycle the byte moves into the shifter. txEmpty returns to 1 on the cycle after the last stop bit, if nothing is held.
- R9: A byte written during a frame is held and sent as the next frame. A byte written while the holding register is full is dropped.
- R10: txDone is a one-cycle pulse in the final clock cycle of the last stop bit of each frame.
- R11: Whenever txEmpty is 1, txLine is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | One-cycle byte write request |
| wrData | input | 8 | Byte to send |
| lineCtrl | input | 6 | Frame format word: [1:0] data length, [2] two stop bits, [3] parity sense, [4] fixed parity, [5] parity enable |
| divInt | input | DIV_W (16) | Integer divisor; 0 means not configured |
| divFrac | input | FRAC_W (3) | Fractional divisor term, in clock cycles per bit |
| txLine | output | 1 | Serial output, idle high |
| bufEmpty | output | 1 | Holding register is free |
| txEmpty | output | 1 | Nothing held and no frame in progress |
| txDone | output | 1 | End-of-frame pulse |

## Verification
The bench builds the block with its default DIV_W of 16 and FRAC_W of 3. It programs divisors of 1 and 2 with fractions 0, 3, 5 and 7, so bit periods stay between 32 and 53 cycles. This keeps every frame short enough to run all data lengths, every parity mode and both stop settings. The nonzero fractions make the sixteen ticks of a bit unequal in length. The bench checks the exact position of the done pulse, which shows that the stretched ticks add up to the stated period. Back-to-back writes and a zero divisor exercise the holding register and its drop rule.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int DATA_MAX = 8;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
  localparam int FRAME_IDX_W = $clog2(FRAME_MAX);

  // Field order matches the line-control word, MSB first.
  typedef struct packed {
    logic       parEn;
    logic       parStick;
    logic       parEven;
    logic       twoStop;
    logic [1:0] lenSel;
  } lineCfg_t;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic finishFrame;
  } txStrobe_t;

  // Index of the last bit of a frame: start + data + parity + stops - 1.
  function automatic logic [FRAME_IDX_W-1:0] frameLastIdx(input lineCfg_t c);
    return FRAME_IDX_W'(6) + FRAME_IDX_W'(c.lenSel)
         + FRAME_IDX_W'(c.parEn) + FRAME_IDX_W'(c.twoStop);
  endfunction
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              holdFull,
  input  lineCfg_t          cfg,
  input  logic [DIV_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output txStrobe_t         strobes,
  output logic              busy
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int CYC_W = DIV_W + 1;

  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t                 state;
  logic [DIV_W-1:0]       divLat;
  logic [FRAC_W-1:0]      fracLat;
  logic [CYC_W-1:0]       cycCnt;
  logic [SUB_W-1:0]       subCnt;
  logic [FRAME_IDX_W-1:0] bitIdx;
  logic [FRAME_IDX_W-1:0] lastIdx;

  logic             stretch;
  logic [CYC_W-1:0] tickLast;
  logic             tickEnd;
  logic             bitEnd;
  logic             lastBit;

  // The first divFrac ticks of every bit last one extra cycle.
  always_comb begin
    stretch  = int'(subCnt) < int'(fracLat);
    tickLast = {1'b0, divLat} + CYC_W'(stretch);
    tickEnd  = (state == ST_SEND) && (cycCnt == tickLast);
    bitEnd   = tickEnd && (subCnt == SUB_W'(OVERSAMPLE - 1));
    lastBit  = bitIdx == lastIdx;
  end

  always_comb begin
    strobes             = '0;
    strobes.loadFrame   = (state == ST_IDLE) && holdFull && (divInt != '0);
    strobes.finishFrame = bitEnd && lastBit;
    strobes.shiftBit    = bitEnd && !lastBit;
  end

  assign busy = (state == ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      divLat  <= '0;
      fracLat <= '0;
      cycCnt  <= '0;
      subCnt  <= '0;
      bitIdx  <= '0;
      lastIdx <= '0;
    end else if (strobes.loadFrame) begin
      state   <= ST_SEND;
      divLat  <= divInt;
      fracLat <= divFrac;
      lastIdx <= frameLastIdx(cfg);
      cycCnt  <= '0;
      subCnt  <= '0;
      bitIdx  <= '0;
    end else if (state == ST_SEND) begin
      if (tickEnd) begin
        cycCnt <= '0;
        subCnt <= (subCnt == SUB_W'(OVERSAMPLE - 1)) ? '0 : subCnt + 1'b1;
        if (bitEnd) begin
          if (lastBit) state <= ST_IDLE;
          else bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrStrobe,
  input  logic [DATA_MAX-1:0] wrData,
  input  lineCfg_t            cfg,
  input  txStrobe_t           strobes,
  output logic                holdFull,
  output logic                txLine
);
  logic [DATA_MAX-1:0]  holdData;
  logic [FRAME_MAX-1:0] frameReg;
  logic [FRAME_MAX-1:0] frameNext;
  logic [DATA_MAX-1:0]  dataMasked;
  logic                 parBit;
  int                   dataBits;

  // Build the whole frame, unused upper positions high, at load time.
  always_comb begin
    dataBits   = 5 + int'(cfg.lenSel);
    dataMasked = holdData & (8'hFF >> (2'd3 - cfg.lenSel));
    if (cfg.parStick) parBit = ~cfg.parEven;
    else if (cfg.parEven) parBit = ^dataMasked;
    else parBit = ~^dataMasked;
    frameNext    = '1;
    frameNext[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < dataBits) frameNext[i+1] = holdData[i];
    end
    if (cfg.parEn) frameNext[dataBits+1] = parBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else if (strobes.loadFrame) begin
      holdFull <= 1'b0;
    end else if (wrStrobe && !holdFull) begin
      holdFull <= 1'b1;
      holdData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frameReg <= '1;
    else if (strobes.loadFrame) frameReg <= frameNext;
    else if (strobes.shiftBit) frameReg <= {1'b1, frameReg[FRAME_MAX-1:1]};
  end

  assign txLine = frameReg[0];
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [7:0]        wrData,
  input  logic [5:0]        lineCtrl,
  input  logic [DIV_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              txLine,
  output logic              bufEmpty,
  output logic              txEmpty,
  output logic              txDone
);
  lineCfg_t  cfg;
  txStrobe_t strobes;
  logic      holdFull;
  logic      busy;

  assign cfg = lineCfg_t'(lineCtrl);

  uart_tx_ctrl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .holdFull(holdFull), .cfg(cfg),
    .divInt(divInt), .divFrac(divFrac), .strobes(strobes), .busy(busy)
  );

  uart_tx_datapath data_i (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrData(wrData),
    .cfg(cfg), .strobes(strobes), .holdFull(holdFull), .txLine(txLine)
  );

  assign bufEmpty = !holdFull;
  assign txEmpty  = !holdFull && !busy;
  assign txDone   = strobes.finishFrame;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrStrobe,
  input logic [DIV_W-1:0] divInt,
  input logic             txLine,
  input logic             bufEmpty,
  input logic             txEmpty,
  input logic             txDone
);
  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txEmpty |-> txLine);

  // R8
  write_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && bufEmpty) |=> (!bufEmpty && !txEmpty));

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txDone |=> !txDone);

  // R8
  done_then_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txDone && bufEmpty && !wrStrobe) |=> txEmpty);

  // R7
  zero_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divInt == '0 && txEmpty) |=> txLine);

  // R2
  start_only_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txLine) |-> !txEmpty);
endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .divInt(divInt),
  .txLine(txLine), .bufEmpty(bufEmpty), .txEmpty(txEmpty), .txDone(txDone)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [7:0] data;
    logic [5:0] lcr;
    int         div;
    int         frac;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  wrData = '0;
  logic [5:0]  lineCtrl = 6'b000011;
  logic [15:0] divInt = 16'd1;
  logic [2:0]  divFrac = 3'd0;
  logic        txLine, bufEmpty, txEmpty, txDone;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrData(wrData),
    .lineCtrl(lineCtrl), .divInt(divInt), .divFrac(divFrac),
    .txLine(txLine), .bufEmpty(bufEmpty), .txEmpty(txEmpty), .txDone(txDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input bit expectSent);
    @(negedge clk);
    wrStrobe = 1'b1;
    wrData   = d;
    if (expectSent) sbq.push_back('{d, lineCtrl, int'(divInt), int'(divFrac)});
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (txEmpty !== 1'b1);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops the expected item at each start bit and checks the frame.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txLine === 1'b0) begin
        if (sbq.size() == 0) begin
          check(0, "R9", "unexpected frame start", 1, 0);
          do @(negedge clk); while (txEmpty !== 1'b1);
        end else begin
          exp_t e;
          logic [15:0] bits;
          string tags[16];
          int nData, idx, per;
          logic [7:0] m;
          logic par;
          e = sbq.pop_front();
          nData = 5 + int'(e.lcr[1:0]);
          m = e.data & (8'hFF >> (3 - e.lcr[1:0]));
          bits = '0;
          bits[0] = 1'b0; tags[0] = "R2";
          for (int i = 0; i < nData; i++) begin
            bits[1+i] = e.data[i];
            tags[1+i] = "R2";
          end
          idx = 1 + nData;
          if (e.lcr[5]) begin
            if (e.lcr[4]) par = ~e.lcr[3];
            else if (e.lcr[3]) par = ^m;
            else par = ~^m;
            bits[idx] = par;
            tags[idx] = e.lcr[4] ? "R5" : "R4";
            idx++;
          end
          bits[idx] = 1'b1; tags[idx] = "R3"; idx++;
          if (e.lcr[2]) begin bits[idx] = 1'b1; tags[idx] = "R3"; idx++; end
          per = 16 * e.div + e.frac + 16;
          repeat (per / 2) @(negedge clk);
          for (int k = 0; k < idx; k++) begin
            if (k > 0) repeat (per) @(negedge clk);
            check(txLine === bits[k], tags[k], $sformatf("frame bit %0d", k),
                  int'(txLine), int'(bits[k]));
          end
          repeat (per - per / 2 - 2) @(negedge clk);
          check(txDone === 1'b0, "R10", "done before last cycle (R6 period)",
                int'(txDone), 0);
          @(negedge clk);
          check(txDone === 1'b1, "R10", "done in last cycle (R6 period)",
                int'(txDone), 1);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txLine === 1'b1, "R1", "txLine at reset", int'(txLine), 1);
    check(bufEmpty === 1'b1, "R1", "bufEmpty at reset", int'(bufEmpty), 1);
    check(txEmpty === 1'b1, "R1", "txEmpty at reset", int'(txEmpty), 1);
    check(txDone === 1'b0, "R1", "txDone at reset", int'(txDone), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(txLine === 1'b1, "R11", "idle line high", int'(txLine), 1);

    // 8 data bits, no parity, one stop; flag timing (R8)
    lineCtrl = 6'b000011; divInt = 16'd1; divFrac = 3'd0;
    sendByte(8'hA5, 1);
    check(bufEmpty === 1'b0, "R8", "bufEmpty after write", int'(bufEmpty), 0);
    check(txEmpty === 1'b0, "R8", "txEmpty after write", int'(txEmpty), 0);
    @(negedge clk);
    check(bufEmpty === 1'b1, "R8", "bufEmpty after load", int'(bufEmpty), 1);
    check(txEmpty === 1'b0, "R8", "txEmpty during frame", int'(txEmpty), 0);
    waitIdle();
    check(txEmpty === 1'b1 && txLine === 1'b1, "R8", "idle after frame",
          int'(txEmpty), 1);

    // 5 bits, even parity, two stops, fractional divisor (R3 R4 R6)
    lineCtrl = 6'b101100; divInt = 16'd2; divFrac = 3'd5;
    sendByte(8'hFB, 1);
    waitIdle();
    sendByte(8'h07, 1);
    waitIdle();

    // 7 bits, odd parity, one stop
    lineCtrl = 6'b100010; divInt = 16'd1; divFrac = 3'd7;
    sendByte(8'h55, 1);
    waitIdle();
    sendByte(8'h80, 1);
    waitIdle();

    // fixed parity (R5)
    lineCtrl = 6'b110011; divFrac = 3'd0;
    sendByte(8'h00, 1);
    waitIdle();
    lineCtrl = 6'b111011;
    sendByte(8'hFF, 1);
    waitIdle();

    // holding register and drop (R9), 6 bits two stops
    lineCtrl = 6'b000101; divFrac = 3'd3;
    sendByte(8'h3C, 1);
    @(negedge clk);
    sendByte(8'h2A, 1);
    check(bufEmpty === 1'b0, "R9", "held byte occupies buffer", int'(bufEmpty), 0);
    sendByte(8'h11, 0);
    waitIdle();
    repeat (300) @(negedge clk);
    check(sbq.size() == 0, "R9", "queued frames outstanding", sbq.size(), 0);

    // zero divisor (R7)
    lineCtrl = 6'b000011; divInt = 16'd0; divFrac = 3'd0;
    sendByte(8'h81, 0);
    check(bufEmpty === 1'b0, "R7", "byte held while unconfigured", int'(bufEmpty), 0);
    begin
      int lowSeen = 0;
      for (int c = 0; c < 2000; c++) begin
        @(negedge clk);
        if (txLine !== 1'b1) lowSeen++;
      end
      check(lowSeen == 0, "R7", "line low cycles with zero divisor", lowSeen, 0);
    end
    @(negedge clk);
    sbq.push_back('{8'h81, lineCtrl, 1, 0});
    divInt = 16'd1;
    waitIdle();
    repeat (100) @(negedge clk);
    check(sbq.size() == 0, "R7", "held frame sent after divisor set", sbq.size(), 0);
    summary();
  end
endmodule